// File: doc/BRIEF.md
# Register-Controlled System Clock Divider

This block sits on the main oscillator clock and turns it into a set of single-cycle enable strobes: one for the CPU and three for peripherals. All logic stays in the main clock domain. The CPU strobe runs at the main rate divided by 1, 2, 4, 8 or 16. The peripheral strobes run at the main rate, at one eighth of it and at one thirty-second of it. Software controls the block through two byte-wide control registers on a small write port. They hold the ratio selection, the oscillator drive-strength select, a peripheral-gating bit for WAIT, and a write-one stop command.

There are two low-power states, each held in a latch. A WAIT strobe marks the core as waiting, and the peripheral strobes are suppressed while the core waits, but only if the gating bit is set. A stop command halts the prescaler and every strobe, and drops the oscillator-run flag. An interrupt request or an NMI releases both latches, and so does reset. Reset and entry to stop also return the ratio override and the drive-strength select to their defaults, so the core always wakes at divide-by-8 with full drive. A new ratio only takes effect at the end of the current CPU period, so no CPU period is ever cut short.

Top module: `clkdiv_top`

## Requirements
- R1: While reset is asserted and after it is released, `osc_run` is 1, `drive_hi` is 1 and the ratio override is set. Counting falling clock edges from the release of reset, the first `cpu_ce` pulse appears on the 7th. Pulses then repeat every 8 cycles.
- R2: Register 0 holds the override at bit 6. When that bit is 0, the field at bits 7:6 of register 1 sets the CPU period: 00 gives 1 cycle, 01 gives 2, 10 gives 4 and 11 gives 16.
- R3: When register 0 bit 6 is 1, the CPU period is 8 cycles, whatever the bits 7:6 field of register 1 holds.
- R4: A ratio written during a CPU period does not shorten or stretch that period. The period after it uses the new ratio.
- R5: `per_ce1` is high on every cycle in which the oscillator runs and the peripherals are not gated. `per_ce8` repeats every 8 cycles and `per_ce32` every 32. Whenever `per_ce32` is high, `per_ce8` and `per_ce1` are high as well.
- R6: A `wait_exec` strobe sets a wait latch. While that latch is set and register 0 bit 2 is 1, all peripheral strobes stay low; when bit 2 is 0, the peripheral strobes are unaffected. `irq_req` or `nmi` clears the latch, and the strobes resume on the next cycle.
- R7: Writing register 1 with bit 0 set stops the oscillator from the next cycle. `osc_run` falls and every strobe stays low. `irq_req` or `nmi` restarts it on the next cycle.
- R8: Entering stop sets the ratio override and `drive_hi`, even if the data written had those bits cleared. After wake-up the CPU period is 8.
- R9: `drive_hi` follows bit 5 of the last write to register 1, except where R8 forces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 = register 0, 1 = register 1 |
| wr_data | input | 8 | Write data |
| wait_exec | input | 1 | WAIT instruction executed |
| irq_req | input | 1 | Interrupt request (wake) |
| nmi | input | 1 | Non-maskable interrupt (wake) |
| cpu_ce | output | 1 | CPU clock enable strobe |
| per_ce1 | output | 1 | Peripheral enable, undivided |
| per_ce8 | output | 1 | Peripheral enable, divide by 8 |
| per_ce32 | output | 1 | Peripheral enable, divide by 32 |
| osc_run | output | 1 | Main oscillator running flag |
| drive_hi | output | 1 | Oscillator drive-strength select (1 = full) |

## Verification
The assertions check four things on every cycle:
- every CPU period is a power of two no larger than 16;
- the peripheral strobes nest;
- stop silences all strobes, and a stop write or a wake takes effect after exactly one cycle;
- the drive select is high whenever stop begins.

Some behaviour only the bench scenarios can show:
- which period each ratio encoding produces, and that the override masks the field;
- the exact latency of the first strobe after reset;
- that a ratio change waits for the current period to end;
- that WAIT gating depends on the gating bit and releases on either wake source.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   localparam int REG_W       = 8;
   // register 0 fields
   localparam int R0_FORCE8   = 6;
   localparam int R0_PERSTOP  = 2;
   // register 1 fields
   localparam int R1_SEL_LSB  = 6;
   localparam int R1_DRIVE    = 5;
   localparam int R1_STOP     = 0;
   // log2 of the forced / reset CPU ratio
   localparam int FORCED_LOG  = 3;

   typedef struct packed {
      logic       force8;
      logic       per_stop;
      logic [1:0] sel;
      logic       drive;
   } clk_ctrl_t;

   function automatic logic [2:0] ratio_log(input clk_ctrl_t c);
      logic [2:0] r;
      if (c.force8) r = 3'(FORCED_LOG);
      else begin
         case (c.sel)
            2'd0:    r = 3'd0;
            2'd1:    r = 3'd1;
            2'd2:    r = 3'd2;
            default: r = 3'd4;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
   import clkdiv_pkg::*;
#(
   parameter int DATA_W = REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wait_exec,
   input  logic              wake,
   output clk_ctrl_t         ctrl,
   output logic              stop_q,
   output logic              wait_q
);

   generate
      if (DATA_W <= R0_FORCE8 || DATA_W <= R1_SEL_LSB + 1) begin : g_bad_width
         $error("clkdiv_regs: DATA_W too narrow for field layout");
      end
   endgenerate

   clk_ctrl_t ctrl_q;
   logic      wr0, wr1, stop_req;

   assign wr0      = wr_en && !wr_addr;
   assign wr1      = wr_en &&  wr_addr;
   assign stop_req = wr1 && wr_data[R1_STOP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q.force8   <= 1'b1;
         ctrl_q.per_stop <= 1'b0;
         ctrl_q.sel      <= 2'b00;
         ctrl_q.drive    <= 1'b1;
      end else begin
         if (wr0) begin
            ctrl_q.force8   <= wr_data[R0_FORCE8];
            ctrl_q.per_stop <= wr_data[R0_PERSTOP];
         end
         if (wr1) begin
            ctrl_q.sel   <= wr_data[R1_SEL_LSB +: 2];
            ctrl_q.drive <= wr_data[R1_DRIVE];
         end
         if (stop_req) begin
            ctrl_q.force8 <= 1'b1;
            ctrl_q.drive  <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
         wait_q <= 1'b0;
      end else begin
         if (wake)          stop_q <= 1'b0;
         else if (stop_req) stop_q <= 1'b1;
         if (wake)           wait_q <= 1'b0;
         else if (wait_exec) wait_q <= 1'b1;
      end
   end

   assign ctrl = ctrl_q;

endmodule

// File: rtl/clkdiv_prescaler.sv
module clkdiv_prescaler #(
   parameter int CNT_W   = 5,
   parameter int MID_LOG = 3,
   parameter int HI_LOG  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic gate,
   output logic ce_base,
   output logic ce_mid,
   output logic ce_hi
);

   localparam int NTAPS = 2;

   generate
      if (HI_LOG > CNT_W)      begin : g_chk_hi  $error("clkdiv_prescaler: HI_LOG exceeds CNT_W"); end
      if (MID_LOG >= HI_LOG)   begin : g_chk_mid $error("clkdiv_prescaler: MID_LOG must be below HI_LOG"); end
      if (MID_LOG < 1)         begin : g_chk_lo  $error("clkdiv_prescaler: MID_LOG must be at least 1"); end
   endgenerate

   logic [CNT_W-1:0] pcnt;
   logic             en;
   logic [NTAPS-1:0] tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pcnt <= '0;
      else if (run) pcnt <= pcnt + 1'b1;
   end

   assign en = run && !gate;

   generate
      for (genvar i = 0; i < NTAPS; i++) begin : g_tap
         localparam int L = (i == 0) ? MID_LOG : HI_LOG;
         assign tap[i] = en && (&pcnt[L-1:0]);
      end
   endgenerate

   assign ce_base = en;
   assign ce_mid  = tap[0];
   assign ce_hi   = tap[1];

endmodule

// File: rtl/clkdiv_cpu.sv
module clkdiv_cpu #(
   parameter int CPU_W     = 4,
   parameter int RESET_LOG = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] req_log,
   output logic       cpu_ce
);

   localparam int MAX_LOG = 4;

   generate
      if (CPU_W < MAX_LOG)      begin : g_chk_w   $error("clkdiv_cpu: CPU_W too small for divide-by-16"); end
      if (RESET_LOG > MAX_LOG)  begin : g_chk_rst $error("clkdiv_cpu: RESET_LOG out of range"); end
   endgenerate

   logic [CPU_W-1:0] dcnt;
   logic [CPU_W-1:0] reload;

   assign reload = CPU_W'((32'd1 << req_log) - 32'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dcnt <= CPU_W'((32'd1 << RESET_LOG) - 32'd1);
      else if (run) begin
         if (dcnt == '0) dcnt <= reload;
         else            dcnt <= dcnt - 1'b1;
      end
   end

   assign cpu_ce = run && (dcnt == '0);

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
   import clkdiv_pkg::*;
#(
   parameter int DATA_W   = REG_W,
   parameter int PRE_W    = 5,
   parameter int MID_LOG  = 3,
   parameter int HI_LOG   = 5,
   parameter int CPU_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wait_exec,
   input  logic              irq_req,
   input  logic              nmi,
   output logic              cpu_ce,
   output logic              per_ce1,
   output logic              per_ce8,
   output logic              per_ce32,
   output logic              osc_run,
   output logic              drive_hi
);

   clk_ctrl_t ctrl;
   logic      stop_q, wait_q, wake, run, per_gate;

   assign wake = irq_req || nmi;

   clkdiv_regs #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wait_exec (wait_exec),
      .wake      (wake),
      .ctrl      (ctrl),
      .stop_q    (stop_q),
      .wait_q    (wait_q)
   );

   assign run      = !stop_q;
   assign per_gate = wait_q && ctrl.per_stop;

   clkdiv_prescaler #(.CNT_W(PRE_W), .MID_LOG(MID_LOG), .HI_LOG(HI_LOG)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .gate    (per_gate),
      .ce_base (per_ce1),
      .ce_mid  (per_ce8),
      .ce_hi   (per_ce32)
   );

   clkdiv_cpu #(.CPU_W(CPU_W), .RESET_LOG(FORCED_LOG)) u_cpu (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .req_log (ratio_log(ctrl)),
      .cpu_ce  (cpu_ce)
   );

   assign osc_run  = run;
   assign drive_hi = ctrl.drive;

endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wait_exec,
   input logic              irq_req,
   input logic              nmi,
   input logic              cpu_ce,
   input logic              per_ce1,
   input logic              per_ce8,
   input logic              per_ce32,
   input logic              osc_run,
   input logic              drive_hi
);

   logic [5:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap_q <= '0;
      else if (osc_run) begin
         if (cpu_ce) gap_q <= '0;
         else        gap_q <= gap_q + 6'd1;
      end
   end

   p_cpu_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ce |-> (($countones(gap_q + 6'd1) == 1) && (gap_q < 6'd16)));

   p_per_nest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      per_ce32 |-> (per_ce8 && per_ce1));

   p_stop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_run |-> (!cpu_ce && !per_ce1 && !per_ce8 && !per_ce32));

   p_stop_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr && wr_data[0] && !irq_req && !nmi) |=> !osc_run);

   p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req || nmi) |=> osc_run);

   p_stop_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_run) |-> drive_hi);

endmodule

bind clkdiv_top clkdiv_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .wait_exec (wait_exec),
   .irq_req   (irq_req),
   .nmi       (nmi),
   .cpu_ce    (cpu_ce),
   .per_ce1   (per_ce1),
   .per_ce8   (per_ce8),
   .per_ce32  (per_ce32),
   .osc_run   (osc_run),
   .drive_hi  (drive_hi)
);

// File: tb/clkdiv_top_bench.sv
`timescale 1ns/1ps
module clkdiv_top_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en, wr_addr, wait_exec, irq_req, nmi;
   logic [7:0] wr_data;
   logic       cpu_ce, per_ce1, per_ce8, per_ce32, osc_run, drive_hi;

   int n_chk = 0;
   int n_err = 0;
   int g;

   always #2.5 clk = ~clk;

   clkdiv_top u_clkdiv_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wait_exec(wait_exec), .irq_req(irq_req), .nmi(nmi), .cpu_ce(cpu_ce),
      .per_ce1(per_ce1), .per_ce8(per_ce8), .per_ce32(per_ce32),
      .osc_run(osc_run), .drive_hi(drive_hi)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_wait();
      wait_exec = 1'b1; @(negedge clk); wait_exec = 1'b0;
   endtask

   task automatic pulse_irq();
      irq_req = 1'b1; @(negedge clk); irq_req = 1'b0;
   endtask

   task automatic pulse_nmi();
      nmi = 1'b1; @(negedge clk); nmi = 1'b0;
   endtask

   task automatic gap(output int n);
      while (!cpu_ce) @(negedge clk);
      n = 0;
      do begin @(negedge clk); n++; end while (!cpu_ce);
   endtask

   task automatic count_per(input int cycles, output int n);
      n = 0;
      for (int i = 0; i < cycles; i++) begin
         if (per_ce1) n++;
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int n, exp, last8, last32, bad;
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
      wait_exec = 1'b0; irq_req = 1'b0; nmi = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(drive_hi === 1'b1, "R1 drive_hi in reset", int'(drive_hi), 1);
      check(osc_run === 1'b1, "R1 osc_run in reset", int'(osc_run), 1);
      check(cpu_ce === 1'b0, "R1 cpu_ce in reset", int'(cpu_ce), 0);
      rst_n = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!cpu_ce);
      check(n == 7, "R1 first cpu_ce latency", n, 7);
      gap(g);
      check(g == 8, "R1 reset period", g, 8);

      // R2 field sweep with override cleared
      for (int s = 0; s < 4; s++) begin
         wr(1'b0, 8'h00);
         wr(1'b1, 8'((s << 6) | 8'h20));
         gap(g); gap(g);
         exp = (s == 3) ? 16 : (1 << s);
         check(g == exp, "R2 ratio field", g, exp);
      end

      // R3 override masks field
      wr(1'b0, 8'h40);
      for (int s = 0; s < 4; s++) begin
         wr(1'b1, 8'((s << 6) | 8'h20));
         gap(g); gap(g);
         check(g == 8, "R3 forced ratio", g, 8);
      end

      // R4 ratio change waits for end of period
      wr(1'b0, 8'h00);
      wr(1'b1, 8'hE0);
      gap(g); gap(g);
      wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h60;
      n = 0;
      @(negedge clk); n++; wr_en = 1'b0;
      while (!cpu_ce) begin @(negedge clk); n++; end
      check(n == 16, "R4 period in flight", n, 16);
      gap(g);
      check(g == 2, "R4 new period", g, 2);

      // R5 peripheral strobe spacing and nesting
      last8 = -1; last32 = -1; bad = 0; n = 0;
      for (int i = 0; i < 96; i++) begin
         if (per_ce1) n++;
         if (per_ce32 && !(per_ce8 && per_ce1)) bad++;
         if (per_ce8) begin
            if (last8 >= 0 && i - last8 != 8) bad++;
            last8 = i;
         end
         if (per_ce32) begin
            if (last32 >= 0 && i - last32 != 32) bad++;
            last32 = i;
         end
         @(negedge clk);
      end
      check(n == 96, "R5 per_ce1 every cycle", n, 96);
      check(bad == 0, "R5 per_ce8/per_ce32 spacing", bad, 0);
      check(last32 >= 0, "R5 per_ce32 seen", last32, 0);

      // R6 WAIT gating
      wr(1'b0, 8'h04);
      pulse_wait();
      count_per(40, n);
      check(n == 0, "R6 gated during wait", n, 0);
      pulse_irq();
      check(per_ce1 === 1'b1, "R6 irq resumes", int'(per_ce1), 1);
      pulse_wait();
      count_per(20, n);
      check(n == 0, "R6 gated again", n, 0);
      pulse_nmi();
      check(per_ce1 === 1'b1, "R6 nmi resumes", int'(per_ce1), 1);
      wr(1'b0, 8'h00);
      pulse_wait();
      count_per(40, n);
      check(n == 40, "R6 ungated when bit clear", n, 40);
      pulse_irq();

      // R9 drive select
      wr(1'b1, 8'h00);
      check(drive_hi === 1'b0, "R9 drive cleared", int'(drive_hi), 0);
      wr(1'b1, 8'h20);
      check(drive_hi === 1'b1, "R9 drive set", int'(drive_hi), 1);
      wr(1'b1, 8'h40);
      check(drive_hi === 1'b0, "R9 drive cleared with ratio 2", int'(drive_hi), 0);
      gap(g); gap(g);
      check(g == 2, "R9 ratio before stop", g, 2);

      // R7/R8 stop and wake
      wr(1'b1, 8'h41);
      check(osc_run === 1'b0, "R7 osc stops", int'(osc_run), 0);
      check(drive_hi === 1'b1, "R8 drive forced", int'(drive_hi), 1);
      n = 0;
      for (int i = 0; i < 20; i++) begin
         if (cpu_ce || per_ce1 || per_ce8 || per_ce32) n++;
         @(negedge clk);
      end
      check(n == 0, "R7 strobes silent in stop", n, 0);
      pulse_nmi();
      check(osc_run === 1'b1, "R7 nmi wakes", int'(osc_run), 1);
      gap(g); gap(g);
      check(g == 8, "R8 forced ratio after stop", g, 8);
      wr(1'b1, 8'h01);
      check(osc_run === 1'b0, "R7 osc stops again", int'(osc_run), 0);
      pulse_irq();
      check(osc_run === 1'b1, "R7 irq wakes", int'(osc_run), 1);

      finish_run();
   end

endmodule